// File: doc/BRIEF.md
# Single-Channel DMA Engine with Bus Request/Grant

This block moves a block of words between one peripheral and memory while the processor is off the bus. The processor sets it up through a small register port. That port has a device select, a two-bit register select, and read and write strobes. The processor loads a start address and a word count, then writes the control register with the start bit set.

Once armed, the engine raises a bus request. It drives the memory address, read enable and write enable only after the processor answers with a bus grant. A word moves only in a cycle where the peripheral requests service, and the peripheral receives a one-cycle acknowledge for each word. There are two modes. Burst mode keeps the bus for the whole block. Cycle-stealing mode gives the bus back after every word and asks for it again. A sticky done flag reports terminal count.

Top module: `dma_engine`

## Requirements
- R1: Register reads and writes take effect only when `cs` is high and `bus_grant` is low. Otherwise a write changes nothing and `rdata` reads zero. Register select values: 0 is the address, 1 is the word count, 2 is control, and 3 reads zero.
- R2: The start bit is control bit 0 and is write-only. Writing it with a nonzero count raises `bus_req` from the next cycle. No memory strobe appears while the grant has not yet arrived.
- R3: While `bus_grant` is low, `mem_addr` is zero and `mem_we`, `mem_re` and `periph_ack` are low.
- R4: A word moves only in a granted cycle with `periph_req` high. In that cycle `periph_ack` is high. Control bit 1 selects the direction: 0 means memory to peripheral, with `mem_re` high and `per_dout` equal to `mem_rdata`; 1 means peripheral to memory, with `mem_we` high and `mem_wdata` equal to `per_din`.
- R5: Word k of a block goes to start address + k, modulo 2^AW. After the block, the address register reads start + count.
- R6: The count drops by one per word and reads zero at the end. Exactly `count` words move. `done` (control bit 3 on read) rises in the cycle after the last word, and `bus_req` is low from that same cycle.
- R7: Burst mode (control bit 2 = 0) keeps `bus_req` high from the first grant until the last word, so the block uses a single grant.
- R8: Cycle-stealing mode (control bit 2 = 1) drops `bus_req` in the cycle after each word. It asks again only after a cycle in which both `bus_grant` and `bus_req` were low, so each word uses its own grant.
- R9: Writing start while the count is zero sets `done` on the next cycle and never raises `bus_req`.
- R10: `done` stays set until the next accepted start write clears it.
- R11: After reset, `bus_req`, `done` and `periph_ack` are low, and the address, count and control registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device select for register access |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| sel | input | 2 | Register select |
| wdata | input | DW | Register write data |
| rdata | output | DW | Register read data |
| bus_req | output | 1 | Request for the memory bus |
| bus_grant | input | 1 | Bus granted by the processor |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Data read from memory |
| mem_wdata | output | DW | Data written to memory |
| periph_req | input | 1 | Peripheral ready for a word |
| periph_ack | output | 1 | One-cycle acknowledge per word moved |
| per_din | input | DW | Data from the peripheral |
| per_dout | output | DW | Data to the peripheral |
| done | output | 1 | Sticky terminal-count flag |

## Verification
The hardest situation to reach is the release gap in cycle-stealing mode. The bus has to be handed back and re-requested while the grant still lingers. The bench models the processor with a grant that follows `bus_req` one cycle late, so the grant stays high for a cycle after every release, and the bench then confirms that the next request waits for an all-low cycle. A separate hold input keeps the grant away after a start. This shows a pending request with a quiet bus, and it also gives a window in which the registers can be read while the engine is armed.

// File: rtl/dma_engine_pkg.sv
package dma_engine_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ASK   = 2'd1,
    ST_MOVE  = 2'd2,
    ST_YIELD = 2'd3
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_STEAL = 2;
  localparam int CTRL_DONE  = 3;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_engine_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          bus_grant,
  input  logic          idle,
  input  logic          step,
  input  logic          fin,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          dir_q,
  output logic          steal_q,
  output logic          done_q,
  output logic          go
);

  logic          acc_wr;
  logic          acc_rd;
  logic          start_wr;
  logic          addr_en;
  logic          cnt_en;
  logic          ctl_en;
  logic          done_en;
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic          done_d;

  assign acc_wr   = cs && wr && !bus_grant;
  assign acc_rd   = cs && rd && !bus_grant;
  assign start_wr = acc_wr && (sel == SEL_CTRL) && wdata[CTRL_START] && idle;
  assign go       = start_wr && (cnt_q != '0);

  // next-state and enables
  always_comb begin
    addr_en = step || (acc_wr && sel == SEL_ADDR);
    cnt_en  = step || (acc_wr && sel == SEL_COUNT);
    ctl_en  = acc_wr && (sel == SEL_CTRL) && idle;
    done_en = start_wr || fin;
    addr_d  = step ? addr_q + AW'(1) : wdata[AW-1:0];
    cnt_d   = step ? cnt_q - CW'(1)  : wdata[CW-1:0];
    done_d  = start_wr ? (cnt_q == '0) : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (ctl_en) begin
        dir_q   <= wdata[CTRL_DIR];
        steal_q <= wdata[CTRL_STEAL];
      end
      if (done_en) done_q <= done_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (acc_rd) begin
      case (sel)
        SEL_ADDR:  rdata = DW'(addr_q);
        SEL_COUNT: rdata = DW'(cnt_q);
        SEL_CTRL: begin
          rdata[CTRL_DIR]   = dir_q;
          rdata[CTRL_STEAL] = steal_q;
          rdata[CTRL_DONE]  = done_q;
        end
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_engine_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bus_grant,
  input  logic periph_req,
  input  logic steal,
  input  logic last,
  input  logic cnt_zero,
  output logic bus_req,
  output logic word,
  output logic fin,
  output logic idle
);

  dma_state_e state_q;
  dma_state_e state_d;

  always_comb begin
    word    = (state_q == ST_MOVE) && bus_grant && periph_req;
    fin     = word && last;
    bus_req = (state_q == ST_ASK) || (state_q == ST_MOVE);
    idle    = (state_q == ST_IDLE);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (go) state_d = ST_ASK;
      ST_ASK:   if (bus_grant) state_d = ST_MOVE;
      ST_MOVE:  if (word && (last || steal)) state_d = ST_YIELD;
      ST_YIELD: if (!bus_grant) state_d = cnt_zero ? ST_IDLE : ST_ASK;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_engine_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  input  logic          periph_req,
  output logic          periph_ack,
  input  logic [DW-1:0] per_din,
  output logic [DW-1:0] per_dout,
  output logic          done
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic          dir_q;
  logic          steal_q;
  logic          go;
  logic          word;
  logic          fin;
  logic          idle;

  dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .wr        (wr),
    .rd        (rd),
    .sel       (sel),
    .wdata     (wdata),
    .bus_grant (bus_grant),
    .idle      (idle),
    .step      (word),
    .fin       (fin),
    .rdata     (rdata),
    .addr_q    (addr_q),
    .cnt_q     (cnt_q),
    .dir_q     (dir_q),
    .steal_q   (steal_q),
    .done_q    (done),
    .go        (go)
  );

  dma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .bus_grant  (bus_grant),
    .periph_req (periph_req),
    .steal      (steal_q),
    .last       (cnt_q == CW'(1)),
    .cnt_zero   (cnt_q == '0),
    .bus_req    (bus_req),
    .word       (word),
    .fin        (fin),
    .idle       (idle)
  );

  // memory side driven only during a granted word move
  always_comb begin
    mem_addr   = word ? addr_q : '0;
    mem_re     = word && !dir_q;
    mem_we     = word && dir_q;
    mem_wdata  = (word && dir_q)  ? per_din   : '0;
    per_dout   = (word && !dir_q) ? mem_rdata : '0;
    periph_ack = word;
  end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          wr,
  input logic          bus_grant,
  input logic          bus_req,
  input logic          periph_req,
  input logic          periph_ack,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic          steal_q
);

  p_regs_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && bus_grant && !periph_ack) |=> ($stable(addr_q) && $stable(cnt_q)));

  p_mem_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_grant |-> (!mem_we && !mem_re && mem_addr == '0 && !periph_ack));

  p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |-> (periph_req && bus_grant && (mem_we ^ mem_re)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |=> (addr_q == $past(addr_q) + AW'(1)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    periph_ack |=> (cnt_q == $past(cnt_q) - CW'(1)));

  p_done_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !bus_req);

  p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack && !steal_q && cnt_q != CW'(1)) |=> bus_req);

  p_steal_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ack && steal_q) |=> !bus_req);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .wr         (wr),
  .bus_grant  (bus_grant),
  .bus_req    (bus_req),
  .periph_req (periph_req),
  .periph_ack (periph_ack),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr),
  .done       (done),
  .addr_q     (addr_q),
  .cnt_q      (cnt_q),
  .steal_q    (steal_q)
);

// File: tb/sim_dma_engine.sv
`timescale 1ns/1ps
module sim_dma_engine;

  logic        clk;
  logic        rst_n;
  logic        cs, wr, rd;
  logic [1:0]  sel;
  logic [15:0] wdata, rdata;
  logic        bus_req, bus_grant;
  logic [15:0] mem_addr, mem_rdata, mem_wdata;
  logic        mem_re, mem_we;
  logic        periph_req, periph_ack;
  logic [15:0] per_din, per_dout;
  logic        done;

  logic gnt_q, hold_gnt, force_gnt;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 0;

  dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .sel(sel),
    .wdata(wdata), .rdata(rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .periph_req(periph_req), .periph_ack(periph_ack),
    .per_din(per_din), .per_dout(per_dout), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // processor model: grant follows request one cycle late
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= bus_req;
  end
  assign bus_grant = (gnt_q && !hold_gnt) || force_gnt;
  assign mem_rdata = mem_addr ^ 16'h5A5A;

  // vectors: {start addr, count, dir, steal, peripheral pattern}
  localparam logic [35:0] VEC [5] = '{
    {16'h0100, 16'd4, 1'b0, 1'b0, 2'd0},
    {16'h0200, 16'd3, 1'b1, 1'b0, 2'd1},
    {16'h0300, 16'd3, 1'b0, 1'b1, 2'd0},
    {16'hFFFE, 16'd4, 1'b1, 1'b1, 2'd1},
    {16'h0010, 16'd1, 1'b1, 1'b0, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [15:0] v, input logic c);
    cs = c; wr = 1'b1; sel = s; wdata = v;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [15:0] v);
    cs = 1'b1; rd = 1'b1; sel = s;
    #1 v = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic run_vec(input logic [15:0] a0, input logic [15:0] n,
                         input logic d, input logic s, input logic [1:0] pat);
    int words = 0;
    int grants = 0;
    int r3bad = 0, r4bad = 0, r5bad = 0, r7bad = 0, r8bad = 0;
    logic [15:0] exp_a = a0;
    logic [15:0] v;
    logic prev_ack = 0, prev_req = 0, prev_gnt = 0, saw_gnt = 0;
    reg_write(2'd0, a0, 1'b1);
    reg_write(2'd1, n, 1'b1);
    reg_write(2'd2, {13'b0, s, d, 1'b1}, 1'b1);
    for (int c = 0; c < 2000; c++) begin
      periph_req = (pat == 2'd0) ? 1'b1 : (c % 3 != 2);
      per_din    = 16'hC300 + 16'(c);
      #1;
      if (!bus_grant && (mem_we || mem_re || mem_addr != 0 || periph_ack)) r3bad++;
      if (periph_ack) begin
        if (mem_addr != exp_a) r5bad++;
        if (!periph_req || mem_we != d || mem_re != !d) r4bad++;
        if (d ? (mem_wdata != per_din) : (per_dout != (mem_addr ^ 16'h5A5A))) r4bad++;
        exp_a++;
        words++;
      end
      if (bus_grant && !prev_gnt) grants++;
      if (s && prev_ack && bus_req) r8bad++;
      if (s && bus_req && !prev_req && words > 0 && prev_gnt) r8bad++;
      if (!s && saw_gnt && !done && !bus_req) r7bad++;
      if (bus_grant) saw_gnt = 1;
      prev_ack = periph_ack; prev_req = bus_req; prev_gnt = bus_grant;
      if (done && !bus_grant) break;
      @(negedge clk);
    end
    @(negedge clk);
    periph_req = 1'b0;
    chk(r3bad == 0, "R3", "memory strobes without grant", r3bad, 0);
    chk(r4bad == 0, "R4", "strobe/data per word", r4bad, 0);
    chk(r5bad == 0, "R5", "per-word address", r5bad, 0);
    chk(words == int'(n), "R6", "words moved", words, n);
    chk(done == 1'b1, "R6", "done at end", done, 1);
    if (s) begin
      chk(r8bad == 0, "R8", "release gap", r8bad, 0);
      chk(grants == int'(n), "R8", "grants per block", grants, n);
    end else begin
      chk(r7bad == 0, "R7", "request held", r7bad, 0);
      chk(grants == 1, "R7", "grants per block", grants, 1);
    end
    reg_read(2'd0, v);
    chk(v == a0 + n, "R5", "final address", v, a0 + n);
    reg_read(2'd1, v);
    chk(v == 16'd0, "R6", "final count", v, 0);
    reg_read(2'd2, v);
    chk(v == {12'b0, 1'b1, s, d, 1'b0}, "R10", "control readback", v, {12'b0, 1'b1, s, d, 1'b0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rst_n = 1'b0; cs = 0; wr = 0; rd = 0; sel = 0; wdata = 0;
    periph_req = 0; per_din = 0; hold_gnt = 0; force_gnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(!bus_req, "R11", "bus_req after reset", bus_req, 0);
    chk(!done, "R11", "done after reset", done, 0);
    chk(!periph_ack, "R11", "ack after reset", periph_ack, 0);
    reg_read(2'd0, v); chk(v == 0, "R11", "address after reset", v, 0);
    reg_read(2'd1, v); chk(v == 0, "R11", "count after reset", v, 0);
    reg_read(2'd2, v); chk(v == 0, "R11", "control after reset", v, 0);

    // table walk
    for (int i = 0; i < 5; i++)
      run_vec(VEC[i][35:20], VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1:0]);

    // R1 register access gating
    reg_write(2'd0, 16'h0AAA, 1'b1);
    force_gnt = 1'b1;
    reg_write(2'd0, 16'h1234, 1'b1);
    reg_read(2'd0, v); chk(v == 0, "R1", "read while granted", v, 0);
    force_gnt = 1'b0;
    reg_read(2'd0, v); chk(v == 16'h0AAA, "R1", "write while granted ignored", v, 16'h0AAA);
    reg_write(2'd0, 16'h4321, 1'b0);
    reg_read(2'd0, v); chk(v == 16'h0AAA, "R1", "write without select ignored", v, 16'h0AAA);
    reg_read(2'd3, v); chk(v == 0, "R1", "unused select reads zero", v, 0);

    // R9 zero count start
    reg_write(2'd1, 16'd0, 1'b1);
    reg_write(2'd2, 16'h0001, 1'b1);
    begin
      int reqs = 0;
      for (int c = 0; c < 5; c++) begin
        #1 if (bus_req) reqs++;
        @(negedge clk);
      end
      chk(done == 1'b1, "R9", "done on zero count", done, 1);
      chk(reqs == 0, "R9", "no request on zero count", reqs, 0);
    end

    // R2 / R10 with grant held off
    hold_gnt = 1'b1;
    reg_write(2'd0, 16'h0500, 1'b1);
    reg_write(2'd1, 16'd2, 1'b1);
    reg_write(2'd2, 16'h0003, 1'b1);
    #1 chk(bus_req == 1'b1, "R2", "request after start", bus_req, 1);
    reg_read(2'd2, v); chk(v[3] == 1'b0, "R10", "done cleared by start", v[3], 0);
    begin
      int busy = 0;
      periph_req = 1'b1;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        #1 if (mem_we || mem_re || periph_ack || mem_addr != 0) busy++;
      end
      chk(busy == 0, "R2", "no memory activity before grant", busy, 0);
      chk(bus_req == 1'b1, "R2", "request held while waiting", bus_req, 1);
    end
    hold_gnt = 1'b0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (done && !bus_grant) break;
    end
    periph_req = 1'b0;
    chk(done == 1'b1, "R10", "done set after transfer", done, 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10", "done stays set", done, 1);
    reg_read(2'd0, v); chk(v == 16'h0502, "R5", "address after held start", v, 16'h0502);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule